// File: doc/BRIEF.md
# Serial Image Row Deframer

This block sits behind a UART byte receiver and rebuilds image rows from the byte stream. Each frame opens with a sync byte of value 0x55. A control byte carrying the two mirror requests follows it, then a two-byte row number, then one row of 24-bit colour pixels at three bytes per pixel. The block packs every pixel into a 32-bit word with a write strobe. It presents the row number on a 32-bit info word and marks the end of each row with a single-clock pulse, so a line buffer and a frame-store writer further down can place the row.

The block also holds the horizontal and vertical mirror requests as level outputs. The downstream path uses them to reverse the read order of a line and to remap row addresses. When the row number is out of range, the whole frame is dropped. Its payload is still counted through, so that a 0x55 value inside the pixel data is never taken for the start of a frame.

Top module: `img_row_deframer`

## Requirements
- R1: While hunting, every byte other than 0x55 is discarded and produces no output. A 0x55 byte starts a frame.
- R2: The byte after the sync byte sets flip_lr from its bit 4 and flip_ud from its bit 0. Both outputs change only when such a byte is accepted and hold their value between frames.
- R3: The next two bytes form the row number, high byte first. While row_done is high, row_info equals {16'h0000, row number}.
- R4: Each pixel takes three payload bytes. The first byte goes to pix_word[7:0], the second to [15:8] and the third to [23:16], and [31:24] is zero. pix_we is high for exactly one clock, in the clock after the third byte is accepted.
- R5: A frame carries PIX_PER_ROW pixels (default 512, so 1536 payload bytes). After the last of them the block returns to hunting.
- R6: row_done is a one-clock pulse in the clock right after the last pix_we of a row.
- R7: A frame whose row number is ROW_COUNT (default 384) or above gives no pix_we and no row_done, and leaves row_info unchanged. Its payload bytes are consumed without resynchronising, even when they equal 0x55.
- R8: A byte counts only in a clock where rx_valid is high. Idle clocks between bytes change nothing.
- R9: While rst_n is low, the block goes to hunting and clears pix_we, row_done, row_info and both flip outputs, at any point in a frame.
- R10: Frames that follow each other with no idle clock between them are each decoded in full. This includes a frame whose row number wraps back to a lower value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_byte | input | 8 | Received byte |
| rx_valid | input | 1 | rx_byte holds a new byte this clock |
| pix_word | output | 32 | Packed pixel, colour in [23:0] |
| pix_we | output | 1 | One-clock strobe per completed pixel |
| row_info | output | 32 | Row number in [15:0], upper bits zero |
| row_done | output | 1 | One-clock pulse ending a row |
| flip_lr | output | 1 | Horizontal mirror request |
| flip_ud | output | 1 | Vertical mirror request |

## Verification
A table of frames drives the deframer with different control bytes and row numbers. Some frames have idle clocks between bytes, some have junk bytes in front of the sync byte, and some follow each other with no gap. These patterns separate correct byte packing and hunting from off-by-one counting and from decoding the row number in the wrong byte order. Row numbers 383, 384 and 0xFFFF sit on both sides of the range limit. Out-of-range frames carry a payload made only of 0x55 bytes, which exposes any false resynchronisation. Directed cases cover reset in the middle of a frame and non-sync bytes sent while idle.

// File: rtl/img_row_pkg.sv
package img_row_pkg;
  typedef enum logic [2:0] {
    ST_HUNT,
    ST_CTRL,
    ST_IDXH,
    ST_IDXL,
    ST_DATA,
    ST_SKIP
  } prs_state_t;
endpackage

// File: rtl/img_row_hdr.sv
module img_row_hdr
  import img_row_pkg::*;
#(
  parameter logic [7:0] SYNC_BYTE = 8'h55,
  parameter int         ROW_COUNT = 384,
  parameter int         LR_BIT    = 4,
  parameter int         UD_BIT    = 0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  rx_byte,
  input  logic        rx_valid,
  input  logic        row_last,
  output prs_state_t  state,
  output logic [15:0] row_idx,
  output logic        flip_lr,
  output logic        flip_ud
);
  localparam logic [15:0] ROW_LIMIT = 16'(ROW_COUNT);

  prs_state_t  state_n;
  logic [7:0]  idx_hi, idx_hi_n;
  logic [15:0] row_idx_n;
  logic        flip_lr_n, flip_ud_n;
  logic [15:0] idx_rx;

  assign idx_rx = {idx_hi, rx_byte};

  always_comb begin
    state_n   = state;
    idx_hi_n  = idx_hi;
    row_idx_n = row_idx;
    flip_lr_n = flip_lr;
    flip_ud_n = flip_ud;
    if (rx_valid) begin
      unique case (state)
        ST_HUNT: if (rx_byte == SYNC_BYTE) state_n = ST_CTRL;
        ST_CTRL: begin
          flip_lr_n = rx_byte[LR_BIT];
          flip_ud_n = rx_byte[UD_BIT];
          state_n   = ST_IDXH;
        end
        ST_IDXH: begin
          idx_hi_n = rx_byte;
          state_n  = ST_IDXL;
        end
        ST_IDXL: begin
          if (idx_rx < ROW_LIMIT) begin
            row_idx_n = idx_rx;
            state_n   = ST_DATA;
          end else begin
            state_n = ST_SKIP;
          end
        end
        ST_DATA, ST_SKIP: if (row_last) state_n = ST_HUNT;
        default: state_n = ST_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_HUNT;
      idx_hi  <= 8'h00;
      row_idx <= 16'h0000;
      flip_lr <= 1'b0;
      flip_ud <= 1'b0;
    end else begin
      state   <= state_n;
      idx_hi  <= idx_hi_n;
      row_idx <= row_idx_n;
      flip_lr <= flip_lr_n;
      flip_ud <= flip_ud_n;
    end
  end

  // R1
  sync_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_CTRL && $past(state) == ST_HUNT) |-> $past(rx_valid && rx_byte == SYNC_BYTE));

  // R2
  flip_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(state == ST_CTRL && rx_valid) |=> $stable({flip_lr, flip_ud}));

  // R7
  idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DATA) |-> (row_idx < ROW_LIMIT));
endmodule

// File: rtl/img_row_pack.sv
module img_row_pack #(
  parameter int PIX_PER_ROW = 512
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  rx_byte,
  input  logic        take,
  input  logic        keep,
  output logic        row_last,
  output logic [31:0] pix_word,
  output logic        pix_we,
  output logic        row_done
);
  localparam int CNT_W = (PIX_PER_ROW > 1) ? $clog2(PIX_PER_ROW) : 1;
  localparam logic [CNT_W-1:0] LAST_PIX = CNT_W'(PIX_PER_ROW - 1);

  logic [1:0]       phase, phase_n;
  logic [CNT_W-1:0] pcnt, pcnt_n;
  logic [7:0]       b0, b0_n, b1, b1_n;
  logic [31:0]      pix_word_n;
  logic             pix_we_n, last_q, last_n;
  logic             pix_end;

  assign pix_end  = (phase == 2'd2);
  assign row_last = pix_end && (pcnt == LAST_PIX);

  always_comb begin
    phase_n    = phase;
    pcnt_n     = pcnt;
    b0_n       = b0;
    b1_n       = b1;
    pix_we_n   = 1'b0;
    last_n     = 1'b0;
    pix_word_n = pix_word;
    if (take) begin
      if (pix_end) begin
        phase_n = 2'd0;
        pcnt_n  = row_last ? '0 : pcnt + 1'b1;
        if (keep) begin
          pix_we_n   = 1'b1;
          last_n     = row_last;
          pix_word_n = {8'h00, rx_byte, b1, b0};
        end
      end else begin
        phase_n = phase + 2'd1;
        if (phase == 2'd0) b0_n = rx_byte;
        else               b1_n = rx_byte;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= 2'd0;
      pcnt     <= '0;
      b0       <= 8'h00;
      b1       <= 8'h00;
      pix_word <= 32'h0;
      pix_we   <= 1'b0;
      last_q   <= 1'b0;
      row_done <= 1'b0;
    end else begin
      phase    <= phase_n;
      pcnt     <= pcnt_n;
      b0       <= b0_n;
      b1       <= b1_n;
      pix_word <= pix_word_n;
      pix_we   <= pix_we_n;
      last_q   <= last_n;
      row_done <= last_q;
    end
  end

  // R6
  done_after_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
    row_done |-> $past(pix_we));

  // R4
  we_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pix_we |=> !pix_we);
endmodule

// File: rtl/img_row_deframer.sv
module img_row_deframer
  import img_row_pkg::*;
#(
  parameter int         PIX_PER_ROW = 512,
  parameter int         ROW_COUNT   = 384,
  parameter logic [7:0] SYNC_BYTE   = 8'h55
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  rx_byte,
  input  logic        rx_valid,
  output logic [31:0] pix_word,
  output logic        pix_we,
  output logic [31:0] row_info,
  output logic        row_done,
  output logic        flip_lr,
  output logic        flip_ud
);
  prs_state_t  state;
  logic [15:0] row_idx;
  logic        row_last;
  logic        take, keep;

  assign keep     = (state == ST_DATA);
  assign take     = rx_valid && (keep || state == ST_SKIP);
  assign row_info = {16'h0000, row_idx};

  img_row_hdr #(
    .SYNC_BYTE (SYNC_BYTE),
    .ROW_COUNT (ROW_COUNT)
  ) u_hdr (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_byte  (rx_byte),
    .rx_valid (rx_valid),
    .row_last (row_last),
    .state    (state),
    .row_idx  (row_idx),
    .flip_lr  (flip_lr),
    .flip_ud  (flip_ud)
  );

  img_row_pack #(
    .PIX_PER_ROW (PIX_PER_ROW)
  ) u_pack (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_byte  (rx_byte),
    .take     (take),
    .keep     (keep),
    .row_last (row_last),
    .pix_word (pix_word),
    .pix_we   (pix_we),
    .row_done (row_done)
  );

  // R7
  skip_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SKIP) |-> (!pix_we && !row_done));
endmodule

// File: tb/img_row_deframer_bench.sv
module img_row_deframer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int PIX  = 4;
  localparam int ROWS = 384;
  localparam int NVEC = 7;
  // [25] junk before sync, [24] idle gaps, [23:16] control byte, [15:0] row number
  localparam logic [31:0] VEC [NVEC] = '{
    {6'd0, 1'b0, 1'b0, 8'h00, 16'd0},
    {6'd0, 1'b1, 1'b0, 8'h10, 16'd1},
    {6'd0, 1'b0, 1'b1, 8'h01, 16'd383},
    {6'd0, 1'b0, 1'b0, 8'h11, 16'd384},
    {6'd0, 1'b0, 1'b0, 8'h00, 16'h0102},
    {6'd0, 1'b0, 1'b1, 8'h11, 16'hFFFF},
    {6'd0, 1'b0, 1'b0, 8'h10, 16'd2}
  };

  logic        clk, rst_n, rx_valid;
  logic [7:0]  rx_byte;
  logic [31:0] pix_word, row_info;
  logic        pix_we, row_done, flip_lr, flip_ud;

  int checks = 0, errors = 0, cycles = 0;
  int npix, nrow, order_err;
  logic [31:0] cap_pix [PIX];
  logic [31:0] cap_info;
  logic        prev_we;

  img_row_deframer #(.PIX_PER_ROW(PIX), .ROW_COUNT(ROWS)) u_img_row_deframer (
    .clk(clk), .rst_n(rst_n), .rx_byte(rx_byte), .rx_valid(rx_valid),
    .pix_word(pix_word), .pix_we(pix_we), .row_info(row_info),
    .row_done(row_done), .flip_lr(flip_lr), .flip_ud(flip_ud)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    cycles++;
    if (pix_we) begin
      if (npix < PIX) cap_pix[npix] = pix_word;
      npix++;
    end
    if (row_done) begin
      nrow++;
      cap_info = row_info;
      if (!prev_we) order_err++;
    end
    prev_we = pix_we;
    if (cycles > 20000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=<20000 cycles", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b, input bit gap);
    if (gap) begin
      @(negedge clk);
      rx_valid = 1'b0;
    end
    @(negedge clk);
    rx_byte  = b;
    rx_valid = 1'b1;
  endtask

  function automatic logic [7:0] pb(input int f, input int i);
    return 8'(f * 37 + i * 5 + 3);
  endfunction

  task automatic clear_cap();
    npix = 0; nrow = 0; order_err = 0;
  endtask

  task automatic send_frame(input int f, input logic [7:0] ctrl, input logic [15:0] idx,
                            input bit gap, input bit junk, input bit good);
    if (junk) begin
      send(8'h00, 1'b0); send(8'hAA, 1'b0); send(8'h54, 1'b0);
    end
    send(8'h55, gap); send(ctrl, gap); send(idx[15:8], gap); send(idx[7:0], gap);
    for (int i = 0; i < 3 * PIX; i++) send(good ? pb(f, i) : 8'h55, gap);
  endtask

  initial begin
    logic [31:0] exp_info;
    logic        exp_lr, exp_ud;
    rst_n = 1'b0; rx_valid = 1'b0; rx_byte = 8'h00;
    clear_cap();
    prev_we = 1'b0;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk({pix_we, row_done, flip_lr, flip_ud, row_info} == '0, "R9 reset outputs",
        {28'h0, pix_we, row_done, flip_lr, flip_ud}, 32'h0);
    rst_n = 1'b1;
    exp_info = 32'h0; exp_lr = 1'b0; exp_ud = 1'b0;

    for (int v = 0; v < NVEC; v++) begin
      logic [15:0] idx;
      logic [7:0]  ctrl;
      bit          gap, junk, good;
      idx = VEC[v][15:0]; ctrl = VEC[v][23:16]; gap = VEC[v][24]; junk = VEC[v][25];
      good = (idx < ROWS);
      if (v != NVEC - 1) clear_cap();
      send_frame(v, ctrl, idx, gap, junk, good);
      if (v == NVEC - 2) begin
        @(negedge clk);
        rx_valid = 1'b0;
        clear_cap();
        // R10 last frame follows with no idle clock: resend the previous (skipped) frame first
        send_frame(v, ctrl, idx, 1'b0, 1'b0, 1'b0);
        send_frame(v + 1, VEC[v + 1][23:16], VEC[v + 1][15:0], 1'b0, 1'b0, 1'b1);
      end
      @(negedge clk);
      rx_valid = 1'b0;
      repeat (4) @(negedge clk);
      exp_lr = ctrl[4]; exp_ud = ctrl[0];
      if (v == NVEC - 2) begin
        exp_lr = VEC[v + 1][20]; exp_ud = VEC[v + 1][16];
      end
      chk({flip_lr, flip_ud} == {exp_lr, exp_ud}, "R2 flip outputs",
          {30'h0, flip_lr, flip_ud}, {30'h0, exp_lr, exp_ud});
      if (good || v == NVEC - 2) begin
        int f;
        f = (v == NVEC - 2) ? v + 1 : v;
        if (v == NVEC - 2) idx = VEC[v + 1][15:0];
        chk(npix == PIX, "R5 pixel count", npix, PIX);
        for (int p = 0; p < PIX; p++) begin
          logic [31:0] e;
          e = {8'h00, pb(f, 3 * p + 2), pb(f, 3 * p + 1), pb(f, 3 * p)};
          chk(cap_pix[p] === e, "R4 pixel word", cap_pix[p], e);
        end
        chk(nrow == 1 && order_err == 0, "R6 row_done single pulse after last strobe",
            {nrow[15:0], order_err[15:0]}, 32'h0001_0000);
        chk(cap_info === {16'h0, idx}, "R3 row_info", cap_info, {16'h0, idx});
        exp_info = {16'h0, idx};
        if (junk) chk(npix == PIX, "R1 junk before sync discarded", npix, PIX);
        if (gap)  chk(npix == PIX && cap_info === {16'h0, idx}, "R8 idle clocks ignored", npix, PIX);
        if (v == NVEC - 2) chk(cap_info === 32'd2, "R10 back-to-back wrapped row", cap_info, 32'd2);
        if (v == NVEC - 2) v++;
      end else begin
        chk(npix == 0 && nrow == 0, "R7 out-of-range frame silent", {npix[15:0], nrow[15:0]}, 32'h0);
        chk(row_info === exp_info, "R7 row_info unchanged", row_info, exp_info);
      end
    end

    // R1 R2 idle bytes while hunting
    clear_cap();
    for (int i = 0; i < 10; i++) send(8'(i * 3), 1'b0);
    @(negedge clk); rx_valid = 1'b0;
    repeat (4) @(negedge clk);
    chk(npix == 0 && nrow == 0, "R1 non-sync bytes ignored", npix, 0);
    chk({flip_lr, flip_ud} == {exp_lr, exp_ud}, "R2 flips hold between frames",
        {30'h0, flip_lr, flip_ud}, {30'h0, exp_lr, exp_ud});

    // R9 reset mid-frame
    send(8'h55, 1'b0); send(8'h11, 1'b0); send(8'h00, 1'b0); send(8'h05, 1'b0);
    send(8'h01, 1'b0); send(8'h02, 1'b0);
    @(negedge clk); rx_valid = 1'b0; rst_n = 1'b0;
    @(negedge clk);
    chk({pix_we, row_done, flip_lr, flip_ud} == 4'b0 && row_info == 32'h0, "R9 reset mid-frame",
        {28'h0, pix_we, row_done, flip_lr, flip_ud}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    clear_cap();
    send_frame(9, 8'h10, 16'd7, 1'b0, 1'b0, 1'b1);
    @(negedge clk); rx_valid = 1'b0;
    repeat (4) @(negedge clk);
    chk(npix == PIX && cap_info === 32'd7, "R9 frame after reset decoded", cap_info, 32'd7);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule